// File: doc/BRIEF.md
# Streaming Run-Merging Histogram Unit

The block counts how often each small integer value appears in a stream of samples. It takes one sample per clock and keeps the counts in an on-chip bin memory with one read port and one write port. A run of equal consecutive samples is counted in a local run register. The bin memory is touched only when the sample value changes. At that point the finished run is written back to its bin, and the new value's bin is read to seed the next run. This keeps the memory at one read and one write per cycle. It also means no stall is needed when a bin is revisited shortly after it was written.

A `start` pulse first zeroes every bin, one address per cycle, and then opens the counting phase. Samples arrive on a valid/ready handshake. A sample flagged as last closes the run. The final open run is then written to memory and a one-cycle `done` pulse follows. After that, any bin can be read through a separate read address with a one-cycle latency, until the next `start`.

Top module: `run_histo`

## Requirements
- R1: After reset, `s_ready` and `done` are both 0.
- R2: A sample equal to the previously accepted sample of the same run adds exactly one to its value's count, and a run of N equal samples leaves N in that bin.
- R3: When the value changes, the finished run's count is stored in its bin and the new run continues from that bin's stored count. This holds even when a bin is revisited one sample after it was written (pattern A, B, A).
- R4: During the counting phase `s_ready` stays 1 every cycle until the last sample is accepted, so one sample is taken per clock.
- R5: With the last sample accepted at clock edge a, `s_ready` is 0 after edge a and `done` is 1 exactly between edges a+2 and a+3. The final run is then already included in the bin counts, including for a run of a single sample.
- R6: After the edge that samples `start` in the idle state, `s_ready` stays 0 for exactly NBINS = 2^VAL_W cycles while every bin is set to zero. No count from an earlier run survives.
- R7: `done` is high for exactly one cycle per run.
- R8: When not counting, `rd_data` shows the count of bin `rd_addr` one clock after `rd_addr` is presented. The counts stay unchanged until the next `start`.
- R9: Cycles with `s_valid` low during counting add nothing to any bin and do not break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new histogram (clear, then count); used in idle only |
| s_valid | input | 1 | Sample valid |
| s_data | input | VAL_W | Sample value, used as bin index |
| s_last | input | 1 | Marks the final sample of the run |
| s_ready | output | 1 | Block accepts a sample this cycle |
| done | output | 1 | One-cycle pulse after the final run is stored |
| rd_addr | input | VAL_W | Bin index for readout |
| rd_data | output | CNT_W | Count of the bin addressed in the previous cycle |

## Verification
The A, B, A pattern makes a read of a bin coincide with the write of that same bin. A design without write-to-read forwarding would lose the first run of A and report too small a count. A stream of only one value, and a run of just one sample, check the flush: a design that forgot to store the open run would leave those bins at zero. A second run after a first one must find every bin cleared; one that skipped or shortened the clear would show leftover counts. Bubbles inside runs, and the exact cycle of `done` and the ready-low clear window, catch designs that count idle cycles or are off by one cycle.

// File: rtl/histo_pkg.sv
// Shared types for the run-merging histogram unit.
package histo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_COUNT,
        ST_DRAIN,
        ST_FLUSH,
        ST_DONE
    } histo_state_e;
endpackage

// File: rtl/histo_bin_ram.sv
// Bin memory: one synchronous read port and one write port per cycle.
// Assumes: when a read and a write hit the same address in one cycle,
// the read returns the data being written (forwarding). q holds when re=0.
module histo_bin_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: store the count.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port: registered output, same-address write forwarded.
    always_ff @(posedge clk) begin
        if (re) begin
            if (we && (waddr == raddr)) q <= wdata;
            else                        q <= mem[raddr];
        end
    end
endmodule

// File: rtl/histo_ctrl.sv
// Phase controller: idle -> clear all bins -> count -> drain the pipeline
// -> flush the open run -> done pulse -> idle.
// Assumes start is only honoured in idle; s_last marks the final accept.
module histo_ctrl #(
    parameter int VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last_acc,
    output histo_pkg::histo_state_e state,
    output logic [VAL_W-1:0] clr_addr,
    output logic             run_start
);
    import histo_pkg::*;

    localparam logic [VAL_W-1:0] LAST_BIN = {VAL_W{1'b1}};

    histo_state_e st_q;

    assign state     = st_q;
    assign run_start = (st_q == ST_IDLE) && start;

    // Phase sequencing and clear-address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            clr_addr <= '0;
        end else begin
            case (st_q)
                ST_IDLE:  if (start) begin
                              st_q     <= ST_CLEAR;
                              clr_addr <= '0;
                          end
                ST_CLEAR: begin
                              clr_addr <= clr_addr + 1'b1;
                              if (clr_addr == LAST_BIN) st_q <= ST_COUNT;
                          end
                ST_COUNT: if (last_acc) st_q <= ST_DRAIN;
                ST_DRAIN: st_q <= ST_FLUSH;
                ST_FLUSH: st_q <= ST_DONE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // R7: the done state never lasts more than one cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |=> (st_q != ST_DONE));

    // R6: counting is only reached from the clear phase after the last bin.
    p_count_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_CLEAR && st_q == ST_COUNT) |-> ($past(clr_addr) == LAST_BIN));
endmodule

// File: rtl/histo_run_merge.sv
// Run-merging datapath. Stage 0 issues the bin read on a value change;
// stage 1, one cycle later, sees the read data and either extends the run
// or stores the finished run and seeds a new one. Assumes the memory read
// has one cycle latency with same-cycle write forwarding.
module histo_run_merge #(
    parameter int VAL_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_start,
    input  logic             accept,
    input  logic [VAL_W-1:0] s_data,
    input  logic             flush,
    input  logic [CNT_W-1:0] ram_q,
    output logic             re,
    output logic [VAL_W-1:0] raddr,
    output logic             we,
    output logic [VAL_W-1:0] waddr,
    output logic [CNT_W-1:0] wdata
);
    logic             first_q;
    logic [VAL_W-1:0] last_q;
    logic             v1_valid, v1_diff, v1_first;
    logic [VAL_W-1:0] v1_val;
    logic [VAL_W-1:0] prev_q;
    logic [CNT_W-1:0] acc_q;
    logic             change0;

    assign change0 = first_q || (s_data != last_q);
    assign re      = accept && change0;
    assign raddr   = s_data;

    // Write on a value change (not the first sample) or at the flush.
    assign we    = flush || (v1_valid && v1_diff && !v1_first);
    assign waddr = prev_q;
    assign wdata = acc_q;

    // Stage 0: track the last accepted value and the first-sample flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            last_q  <= '0;
        end else if (run_start) begin
            first_q <= 1'b1;
        end else if (accept) begin
            first_q <= 1'b0;
            last_q  <= s_data;
        end
    end

    // Stage 1 register: the sample one cycle behind its read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_valid <= 1'b0;
            v1_diff  <= 1'b0;
            v1_first <= 1'b0;
            v1_val   <= '0;
        end else begin
            v1_valid <= accept;
            v1_diff  <= change0;
            v1_first <= first_q;
            v1_val   <= s_data;
        end
    end

    // Stage 1: extend the run, or start a new one from the stored count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            acc_q  <= '0;
        end else if (v1_valid) begin
            prev_q <= v1_val;
            if (v1_diff) acc_q <= ram_q + CNT_W'(1);
            else         acc_q <= acc_q + CNT_W'(1);
        end
    end

    // R2: a repeat of the same value never touches the bin memory.
    p_no_ram_on_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !first_q && s_data == last_q) |-> !re);

    // R2: inside a run the count grows by exactly one per sample.
    p_run_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_valid && !v1_diff) |=> (acc_q == $past(acc_q) + CNT_W'(1)));

    // R3: a stored run is written to the bin of the value that just ended.
    p_store_prev_bin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_valid && v1_diff && !v1_first && !flush) |-> (waddr != v1_val));
endmodule

// File: rtl/run_histo.sv
// Top of the streaming run-merging histogram unit. Muxes the bin memory
// between the clear sweep, the counting datapath and the host read port.
// Assumes a sample is accepted when s_valid and s_ready are both high.
module run_histo #(
    parameter int VAL_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             s_valid,
    input  logic [VAL_W-1:0] s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             done,
    input  logic [VAL_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data
);
    import histo_pkg::*;

    histo_state_e     state;
    logic [VAL_W-1:0] clr_addr;
    logic             run_start, accept, host_rd, clearing;
    logic             dp_re, dp_we;
    logic [VAL_W-1:0] dp_raddr, dp_waddr;
    logic [CNT_W-1:0] dp_wdata;
    logic             ram_re, ram_we;
    logic [VAL_W-1:0] ram_raddr, ram_waddr;
    logic [CNT_W-1:0] ram_wdata, ram_q;

    assign s_ready  = (state == ST_COUNT);
    assign done     = (state == ST_DONE);
    assign accept   = s_valid && s_ready;
    assign host_rd  = (state == ST_IDLE) || (state == ST_DONE);
    assign clearing = (state == ST_CLEAR);

    histo_ctrl #(.VAL_W(VAL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_acc  (accept && s_last),
        .state     (state),
        .clr_addr  (clr_addr),
        .run_start (run_start)
    );

    histo_run_merge #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_start (run_start),
        .accept    (accept),
        .s_data    (s_data),
        .flush     (state == ST_FLUSH),
        .ram_q     (ram_q),
        .re        (dp_re),
        .raddr     (dp_raddr),
        .we        (dp_we),
        .waddr     (dp_waddr),
        .wdata     (dp_wdata)
    );

    // Memory port selection: clear sweep, counting datapath or host reads.
    always_comb begin
        ram_we    = clearing ? 1'b1     : dp_we;
        ram_waddr = clearing ? clr_addr : dp_waddr;
        ram_wdata = clearing ? '0       : dp_wdata;
        ram_re    = host_rd  ? 1'b1     : dp_re;
        ram_raddr = host_rd  ? rd_addr  : dp_raddr;
    end

    histo_bin_ram #(.ADDR_W(VAL_W), .DATA_W(CNT_W)) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .raddr (ram_raddr),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

    assign rd_data = ram_q;

    // R5: done only follows a cycle in which the final run was written.
    p_flush_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ram_we));

    // R4: ready drops only after a last sample has been accepted.
    p_ready_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !(s_valid && s_last)) |=> s_ready);

    // R8: no memory write while the host read port owns the memory.
    p_bins_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !ram_we);
endmodule

// File: tb/sim_run_histo.sv
// Directed bench for run_histo: one task per scenario, reference counts
// kept in a plain array.
module sim_run_histo;
    localparam int VAL_W = 4;
    localparam int CNT_W = 16;
    localparam int NB    = 1 << VAL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             s_valid = 1'b0;
    logic [VAL_W-1:0] s_data = '0;
    logic             s_last = 1'b0;
    logic             s_ready, done;
    logic [VAL_W-1:0] rd_addr = '0;
    logic [CNT_W-1:0] rd_data;

    int total = 0;
    int bad = 0;
    int model [NB];

    run_histo #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // R6: start a run, measure the clear window, reset the model.
    task automatic begin_run();
        int lo;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lo = 0;
        while (!s_ready && lo < 4 * NB) begin
            lo++;
            @(negedge clk);
        end
        check("R6 clear window", lo, NB);
        for (int i = 0; i < NB; i++) model[i] = 0;
    endtask

    // R4: drive one sample; ready must be high when offered.
    task automatic send(input int v, input bit last);
        check("R4 ready while counting", int'(s_ready), 1);
        s_valid = 1'b1;
        s_data  = VAL_W'(v);
        s_last  = last;
        model[v]++;
        @(negedge clk);
    endtask

    // R9: one idle cycle in the stream.
    task automatic bubble();
        s_valid = 1'b0;
        s_last  = 1'b0;
        @(negedge clk);
    endtask

    // R5/R7: after the last accept, check ready, done timing and pulse width.
    task automatic finish_run();
        s_valid = 1'b0;
        s_last  = 1'b0;
        check("R5 ready low after last", int'(s_ready), 0);
        check("R5 done not yet (a+1)", int'(done), 0);
        @(negedge clk);
        check("R5 done not yet (a+2)", int'(done), 0);
        @(negedge clk);
        check("R5 done at a+3", int'(done), 1);
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
    endtask

    // R8: read every bin and compare with the model.
    task automatic check_bins(input string req);
        for (int i = 0; i < NB; i++) begin
            rd_addr = VAL_W'(i);
            @(negedge clk);
            check(req, int'(rd_data), model[i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready after reset", int'(s_ready), 0);
        check("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_single_value();
        begin_run();
        for (int i = 0; i < 19; i++) send(5, 1'b0);
        send(5, 1'b1);
        finish_run();
        check_bins("R2 run of one value");
    endtask

    task automatic t_revisit();
        begin_run();
        send(3, 1'b0); send(3, 1'b0); send(9, 1'b0); send(3, 1'b0);
        send(9, 1'b0); send(3, 1'b0); send(3, 1'b0); send(9, 1'b0);
        send(0, 1'b0); send(15, 1'b0); send(0, 1'b0); send(15, 1'b1);
        finish_run();
        check_bins("R3 A-B-A revisit");
    endtask

    task automatic t_mixed_bubbles();
        logic [7:0] lfsr = 8'hA5;
        int v = 0;
        begin_run();
        for (int i = 0; i < 299; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[6:5] != 2'b00) v = int'(lfsr[3:0]);
            send(v, 1'b0);
            if (lfsr[7] && lfsr[0]) bubble();
        end
        send(v, 1'b1);
        finish_run();
        check_bins("R9 stream with bubbles");
    endtask

    task automatic t_single_sample();
        begin_run();
        send(12, 1'b1);
        finish_run();
        check_bins("R5 single-sample run and R6 cleared bins");
        repeat (20) @(negedge clk);
        check_bins("R8 bins held while idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_value();
        t_revisit();
        t_mixed_bubbles();
        t_single_sample();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule